// File: doc/BRIEF.md
# Command and event ring handler

This block keeps the host side of two rings shared with a network controller's firmware. Commands flow out through a 64-slot command ring. The host offers 32-bit command words on a valid/ready stream. The block writes each accepted word into the ring slot named by its command producer index, then steps that index. Every ring word, command or event, has the same layout: operation in bits 31:24, flags in bits 23:12 and index in bits 11:0.

Events flow in through a 256-slot event ring. The controller publishes an event producer index. The block reads entries from its consumer index up to that producer index and decodes the 12-bit code in bits 23:12 of each entry. A firmware-up event makes the block post the two bring-up commands by itself. Link-change events and event-error events are reported on single-cycle strobes, together with the raw event word. The consumer index is published only once the ring has been drained.

Back-pressure on the command stream works as follows. A word is taken on a rising edge where both `hcmd_valid` and `hcmd_ready` are high. The host must hold the word steady while valid is high and ready is low. Ready is low during ring initialisation, during the cycle a word is being written, and while a self-generated command is waiting. The event ring memory returns read data one cycle after `ev_rd_en`, and must hold that data until the next read.

Top module: `cmd_evt_ring_ctl`

## Requirements
- R1: While reset is held, and after it, `cmd_pi` and `ev_ci` are 0 and no strobe is high. After reset is released, the block writes zero into all 64 command slots. `hcmd_ready` first goes high 65 cycles after the release.
- R2: A host word accepted on an edge is driven on the write port in the next cycle, at address `cmd_pi`. On the edge after that, `cmd_pi` advances by one modulo 64.
- R3: `hcmd_ready` is low in every cycle in which the command write port is active, so the stream accepts at most one word every two cycles.
- R4: Self-generated commands take priority over the host. While one is pending, `hcmd_ready` stays low, and the two bring-up commands land in consecutive slots even if the host keeps `hcmd_valid` high.
- R5: Event entries are read in ring order from the consumer position up to `ev_pi`, and the position wraps modulo 256.
- R6: `ev_ci` changes only after every entry up to `ev_pi` has been consumed. It then takes the value of `ev_pi`. It never changes partway through a batch.
- R7: An event with code 0x001 makes the block post two commands, in this order: 0x01001000 (operation 0x01, flags 0x001, index 0) and then 0x0B000000 (operation 0x0B, flags 0, index 0).
- R8: An event with code 0x006 raises `link_chg` for one cycle, with the event word on `evt_word`.
- R9: An event with code 0x007 raises `evt_err` for one cycle, with the event word on `evt_word`.
- R10: Any other event code raises no strobe and posts no command. The only effect is that the consumer position advances.
- R11: If a firmware-up event arrives while bring-up commands from an earlier one are still pending, event draining waits. Each firmware-up event yields its own complete pair of commands, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcmd_valid | input | 1 | Host command word offered |
| hcmd_ready | output | 1 | Host command word can be taken |
| hcmd_word | input | 32 | Host command word |
| cr_wr_en | output | 1 | Command ring write strobe |
| cr_wr_addr | output | 6 | Command ring slot being written |
| cr_wr_data | output | 32 | Word written into the command ring |
| cmd_pi | output | 6 | Command producer index |
| ev_pi | input | 8 | Event producer index from the controller |
| ev_rd_en | output | 1 | Event ring read request |
| ev_rd_addr | output | 8 | Event ring slot read |
| ev_rd_data | input | 32 | Event ring data, one cycle after the request |
| ev_ci | output | 8 | Published event consumer index |
| link_chg | output | 1 | Link-change event strobe |
| evt_err | output | 1 | Event-error strobe |
| evt_word | output | 32 | Raw event word for the strobes |

## Verification
Each result has a fixed latency:
- A host word accepted on an edge appears on the write port in the next cycle, and `cmd_pi` moves one edge later.
- An event read is decoded in the cycle after its request, so its strobe is high one cycle after that. Bring-up commands follow within a few cycles.
- `ev_ci` is published two edges after the last entry is decoded.

The bench drives inputs and samples outputs on the falling edge. A scoreboard compares every write-port cycle against the queue of slot and word pairs the driver expected, and every strobe against a queue of expected event words. The timed checks sample `cmd_pi` and `ev_ci` exactly on the falling edges where these latencies place the change.

// File: rtl/cer_pkg.sv
package cer_pkg;

  localparam int OP_W   = 8;
  localparam int FLG_W  = 12;
  localparam int IDX_W  = 12;
  localparam int WORD_W = OP_W + FLG_W + IDX_W;

  // Event codes the handler reacts to
  localparam logic [FLG_W-1:0] EVC_FW_UP = 12'h001;
  localparam logic [FLG_W-1:0] EVC_LINK  = 12'h006;
  localparam logic [FLG_W-1:0] EVC_ERR   = 12'h007;

  // Number of commands posted after firmware comes up
  localparam int BRINGUP_STEPS = 2;

  typedef enum logic {DR_IDLE, DR_DATA} drain_st_e;

  function automatic logic [WORD_W-1:0] pack_word(
      input logic [OP_W-1:0] op, input logic [FLG_W-1:0] flg,
      input logic [IDX_W-1:0] idx);
    return {op, flg, idx};
  endfunction

  function automatic logic [FLG_W-1:0] evt_code(input logic [WORD_W-1:0] w);
    return w[IDX_W +: FLG_W];
  endfunction

  // Step 0: declare host stack up; step 1: start link negotiation, any speed
  function automatic logic [WORD_W-1:0] bringup_word(input int unsigned step);
    case (step)
      0:       return pack_word(8'h01, 12'h001, 12'h000);
      default: return pack_word(8'h0B, 12'h000, 12'h000);
    endcase
  endfunction

endpackage

// File: rtl/cer_bringup_seq.sv
module cer_bringup_seq
  import cer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  output logic              busy,
  output logic [WORD_W-1:0] word
);

  localparam int ST_W = $clog2(BRINGUP_STEPS + 1);
  localparam logic [ST_W-1:0] LAST = ST_W'(BRINGUP_STEPS);

  logic [ST_W-1:0] stage_q;

  assign busy = (stage_q != '0);
  assign word = bringup_word(32'(stage_q) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (!busy) begin
      if (start) stage_q <= ST_W'(1);
    end else if (take) begin
      stage_q <= (stage_q == LAST) ? '0 : stage_q + ST_W'(1);
    end
  end

endmodule

// File: rtl/cer_cmd_writer.sv
module cer_cmd_writer
  import cer_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_valid,
  input  logic [WORD_W-1:0] auto_word,
  output logic              auto_take,
  input  logic              host_valid,
  input  logic [WORD_W-1:0] host_word,
  output logic              host_ready,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              cmd_write,
  output logic [AW-1:0]     prod_idx
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          run_q;
  logic [AW-1:0] clr_q;
  logic          wr_en_q;
  logic          cmd_q;
  logic [AW-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [AW-1:0] pi_q;
  logic          slot_free;
  logic          host_take;

  // Fixed priority: self-generated commands before host commands
  assign slot_free  = run_q && !wr_en_q;
  assign auto_take  = slot_free && auto_valid;
  assign host_ready = slot_free && !auto_valid;
  assign host_take  = host_ready && host_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      clr_q   <= '0;
      wr_en_q <= 1'b0;
      cmd_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      pi_q    <= '0;
    end else begin
      wr_en_q <= 1'b0;
      cmd_q   <= 1'b0;
      if (!run_q) begin
        wr_en_q <= 1'b1;
        addr_q  <= clr_q;
        data_q  <= '0;
        clr_q   <= clr_q + AW'(1);
        if (clr_q == LAST) run_q <= 1'b1;
      end else if (auto_take || host_take) begin
        wr_en_q <= 1'b1;
        cmd_q   <= 1'b1;
        addr_q  <= pi_q;
        data_q  <= auto_take ? auto_word : host_word;
      end
      if (cmd_q) pi_q <= pi_q + AW'(1);
    end
  end

  assign wr_en     = wr_en_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign cmd_write = cmd_q;
  assign prod_idx  = pi_q;

endmodule

// File: rtl/cer_evt_drain.sv
module cer_evt_drain
  import cer_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     prod_idx,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0]     cons_idx,
  input  logic              auto_busy,
  output logic              auto_start,
  output logic              link_stb,
  output logic              err_stb,
  output logic [WORD_W-1:0] evt_word
);

  drain_st_e         st_q;
  logic [AW-1:0]     work_q;
  logic [AW-1:0]     cons_q;
  logic              link_q, err_q;
  logic [WORD_W-1:0] word_q;
  logic [FLG_W-1:0]  code;
  logic              is_up;
  logic              hold;

  assign code       = evt_code(rd_data);
  assign is_up      = (st_q == DR_DATA) && (code == EVC_FW_UP);
  assign hold       = is_up && auto_busy;
  assign auto_start = is_up && !auto_busy;
  assign rd_en      = (st_q == DR_IDLE) && (work_q != prod_idx);
  assign rd_addr    = work_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= DR_IDLE;
      work_q <= '0;
      cons_q <= '0;
      link_q <= 1'b0;
      err_q  <= 1'b0;
      word_q <= '0;
    end else begin
      link_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        DR_IDLE: begin
          if (rd_en)                 st_q   <= DR_DATA;
          else if (work_q != cons_q) cons_q <= work_q;
        end
        default: begin
          if (!hold) begin
            work_q <= work_q + AW'(1);
            st_q   <= DR_IDLE;
            if (code == EVC_LINK) begin
              link_q <= 1'b1;
              word_q <= rd_data;
            end else if (code == EVC_ERR) begin
              err_q  <= 1'b1;
              word_q <= rd_data;
            end
          end
        end
      endcase
    end
  end

  assign cons_idx = cons_q;
  assign link_stb = link_q;
  assign err_stb  = err_q;
  assign evt_word = word_q;

endmodule

// File: rtl/cmd_evt_ring_ctl.sv
module cmd_evt_ring_ctl
  import cer_pkg::*;
#(
  parameter int CMD_DEPTH = 64,
  parameter int EVT_DEPTH = 256,
  localparam int CPI_W = $clog2(CMD_DEPTH),
  localparam int EPI_W = $clog2(EVT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hcmd_valid,
  output logic              hcmd_ready,
  input  logic [WORD_W-1:0] hcmd_word,
  output logic              cr_wr_en,
  output logic [CPI_W-1:0]  cr_wr_addr,
  output logic [WORD_W-1:0] cr_wr_data,
  output logic [CPI_W-1:0]  cmd_pi,
  input  logic [EPI_W-1:0]  ev_pi,
  output logic              ev_rd_en,
  output logic [EPI_W-1:0]  ev_rd_addr,
  input  logic [WORD_W-1:0] ev_rd_data,
  output logic [EPI_W-1:0]  ev_ci,
  output logic              link_chg,
  output logic              evt_err,
  output logic [WORD_W-1:0] evt_word
);

  logic              auto_busy;
  logic              auto_take;
  logic              auto_start;
  logic              cmd_write;
  logic [WORD_W-1:0] auto_word;

  cer_bringup_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (auto_start),
    .take  (auto_take),
    .busy  (auto_busy),
    .word  (auto_word)
  );

  cer_cmd_writer #(.DEPTH(CMD_DEPTH)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_valid (auto_busy),
    .auto_word  (auto_word),
    .auto_take  (auto_take),
    .host_valid (hcmd_valid),
    .host_word  (hcmd_word),
    .host_ready (hcmd_ready),
    .wr_en      (cr_wr_en),
    .wr_addr    (cr_wr_addr),
    .wr_data    (cr_wr_data),
    .cmd_write  (cmd_write),
    .prod_idx   (cmd_pi)
  );

  cer_evt_drain #(.DEPTH(EVT_DEPTH)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_idx   (ev_pi),
    .rd_en      (ev_rd_en),
    .rd_addr    (ev_rd_addr),
    .rd_data    (ev_rd_data),
    .cons_idx   (ev_ci),
    .auto_busy  (auto_busy),
    .auto_start (auto_start),
    .link_stb   (link_chg),
    .err_stb    (evt_err),
    .evt_word   (evt_word)
  );

endmodule

// File: rtl/cer_checker.sv
module cer_checker
  import cer_pkg::*;
#(
  parameter int CPI_W = 6,
  parameter int EPI_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hcmd_ready,
  input logic             cr_wr_en,
  input logic             cmd_write,
  input logic             auto_busy,
  input logic             link_chg,
  input logic             evt_err,
  input logic [CPI_W-1:0] cr_wr_addr,
  input logic [CPI_W-1:0] cmd_pi,
  input logic [FLG_W-1:0] evt_code_i,
  input logic [EPI_W-1:0] ev_ci,
  input logic [EPI_W-1:0] ev_pi
);

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cr_wr_en |-> !hcmd_ready);

  assert_pi_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pi != $past(cmd_pi)) |-> (cmd_pi == $past(cmd_pi) + CPI_W'(1)));

  assert_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |-> (cr_wr_addr == cmd_pi));

  assert_auto_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    auto_busy |-> !hcmd_ready);

  assert_link_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg |-> (evt_code_i == EVC_LINK));

  assert_err_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> (evt_code_i == EVC_ERR));

  assert_ci_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ci != $past(ev_ci)) |-> (ev_ci == $past(ev_pi)));

endmodule

bind cmd_evt_ring_ctl cer_checker #(.CPI_W(CPI_W), .EPI_W(EPI_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hcmd_ready (hcmd_ready),
  .cr_wr_en   (cr_wr_en),
  .cmd_write  (cmd_write),
  .auto_busy  (auto_busy),
  .link_chg   (link_chg),
  .evt_err    (evt_err),
  .cr_wr_addr (cr_wr_addr),
  .cmd_pi     (cmd_pi),
  .evt_code_i (evt_word[23:12]),
  .ev_ci      (ev_ci),
  .ev_pi      (ev_pi)
);

// File: tb/sim_cmd_evt_ring_ctl.sv
module sim_cmd_evt_ring_ctl;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] UP0 = 32'h0100_1000;
  localparam logic [31:0] UP1 = 32'h0B00_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hcmd_valid;
  logic        hcmd_ready;
  logic [31:0] hcmd_word;
  logic        cr_wr_en;
  logic [5:0]  cr_wr_addr;
  logic [31:0] cr_wr_data;
  logic [5:0]  cmd_pi;
  logic [7:0]  ev_pi;
  logic        ev_rd_en;
  logic [7:0]  ev_rd_addr;
  logic [31:0] ev_rd_data = '0;
  logic [7:0]  ev_ci;
  logic        link_chg;
  logic        evt_err;
  logic [31:0] evt_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_evt_ring_ctl u0 (.*);

  logic [31:0] cring [64];
  logic [31:0] ering [256];

  always @(posedge clk) if (cr_wr_en) cring[cr_wr_addr] <= cr_wr_data;
  always @(posedge clk) if (ev_rd_en) ev_rd_data <= ering[ev_rd_addr];

  int total = 0;
  int bad = 0;
  int exp_pi = 0;
  int wp = 0;
  bit sb_on = 0;
  bit log_mode = 0;
  logic [37:0] exp_cq [$];
  logic [32:0] exp_eq [$];
  logic [31:0] wlog [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: command ring writes
  always @(negedge clk) begin
    if (rst_n && sb_on && cr_wr_en) begin
      if (log_mode) wlog.push_back(cr_wr_data);
      else if (exp_cq.size() == 0)
        chk(0, "R10 unexpected command write", {cr_wr_addr, cr_wr_data}, 0);
      else begin
        logic [37:0] e;
        e = exp_cq.pop_front();
        chk({cr_wr_addr, cr_wr_data} == e, "R2/R7 command slot and word",
            {cr_wr_addr, cr_wr_data}, e);
      end
    end
  end

  // Monitor: event strobes
  always @(negedge clk) begin
    if (rst_n && (link_chg || evt_err)) begin
      if (exp_eq.size() == 0)
        chk(0, "R10 unexpected strobe", {evt_err, evt_word}, 0);
      else begin
        logic [32:0] e;
        e = exp_eq.pop_front();
        chk(!(link_chg && evt_err) && ({evt_err, evt_word} == e),
            "R8/R9 strobe and event word", {evt_err, evt_word}, e);
      end
    end
  end

  task automatic host_send(input logic [31:0] w, input bit track);
    if (track) begin
      exp_cq.push_back({6'(exp_pi), w});
      exp_pi = (exp_pi + 1) % 64;
    end
    hcmd_valid = 1'b1;
    hcmd_word  = w;
    while (!hcmd_ready) @(negedge clk);
    @(negedge clk);
    hcmd_valid = 1'b0;
  endtask

  task automatic expect_up();
    exp_cq.push_back({6'(exp_pi), UP0});
    exp_pi = (exp_pi + 1) % 64;
    exp_cq.push_back({6'(exp_pi), UP1});
    exp_pi = (exp_pi + 1) % 64;
  endtask

  task automatic put_evt(input logic [11:0] code, input logic [11:0] idx);
    ering[wp] = {8'h5A, code, idx};
    wp = (wp + 1) % 256;
  endtask

  task automatic run_events();
    ev_pi = 8'(wp);
    while (ev_ci != 8'(wp)) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(negedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int nz;
    int k;
    rst_n = 1'b0;
    hcmd_valid = 1'b0;
    hcmd_word = '0;
    ev_pi = '0;
    for (int i = 0; i < 64; i++) cring[i] = 32'hDEAD_BEEF;
    for (int i = 0; i < 256; i++) ering[i] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!hcmd_ready && cmd_pi == 0 && ev_ci == 0 && !link_chg && !evt_err && !cr_wr_en,
        "R1 reset state", {hcmd_ready, cmd_pi, ev_ci, link_chg, evt_err}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!hcmd_ready && n < 200) begin @(negedge clk); n++; end
    chk(n == 65, "R1 ready after clear of 64 slots", n, 65);
    nz = 0;
    for (int i = 0; i < 64; i++) if (cring[i] != 0) nz++;
    chk(nz == 0, "R1 command slots cleared", nz, 0);
    chk(cmd_pi == 0 && ev_ci == 0, "R1 indices zero after init", {cmd_pi, ev_ci}, 0);
    sb_on = 1;

    // R2/R3: host commands and their timing
    host_send(32'h0A12_3456, 1);
    chk(cr_wr_en && !hcmd_ready, "R3 ready low during write", {cr_wr_en, hcmd_ready}, 2);
    chk(cmd_pi == 0, "R2 index unchanged during write", cmd_pi, 0);
    @(negedge clk);
    chk(cmd_pi == 1, "R2 index advances after write", cmd_pi, 1);
    host_send(32'hFFFF_FFFF, 1);
    host_send(32'h0000_0001, 1);
    repeat (3) @(negedge clk);
    chk(cmd_pi == 3, "R2 index after three commands", cmd_pi, 3);

    // R2: wrap of the command index
    for (int i = 0; i < 66; i++) host_send(32'h7700_0000 | i, 1);
    repeat (3) @(negedge clk);
    chk(cmd_pi == 5, "R2 index wraps modulo 64", cmd_pi, 5);
    chk(exp_cq.size() == 0, "R2 all host commands written", exp_cq.size(), 0);

    // R10: unknown codes consumed silently
    put_evt(12'h002, 12'h000);
    put_evt(12'h123, 12'h055);
    put_evt(12'hFFF, 12'hFFF);
    run_events();
    chk(ev_ci == 3, "R10 consumer advanced over unknown codes", ev_ci, 3);
    chk(cmd_pi == 5, "R10 no command posted", cmd_pi, 5);

    // R6: consumer index published only at end of batch
    for (int i = 0; i < 6; i++) put_evt(12'h0F0, 12'(i));
    ev_pi = 8'(wp);
    repeat (3) @(negedge clk);
    chk(ev_ci == 3, "R6 consumer held during batch", ev_ci, 3);
    while (ev_ci != 8'(wp)) @(negedge clk);
    chk(ev_ci == 9, "R6 consumer published at end", ev_ci, 9);

    // R8/R9: strobes
    put_evt(12'h006, 12'h001);
    exp_eq.push_back({1'b0, 8'h5A, 12'h006, 12'h001});
    put_evt(12'h007, 12'h0AB);
    exp_eq.push_back({1'b1, 8'h5A, 12'h007, 12'h0AB});
    put_evt(12'h006, 12'h000);
    exp_eq.push_back({1'b0, 8'h5A, 12'h006, 12'h000});
    run_events();
    chk(exp_eq.size() == 0, "R8/R9 all strobes seen", exp_eq.size(), 0);

    // R7: firmware-up posts bring-up commands
    put_evt(12'h001, 12'h000);
    expect_up();
    run_events();
    chk(exp_cq.size() == 0, "R7 bring-up commands posted", exp_cq.size(), 0);
    chk(cmd_pi == 7, "R7 index after bring-up", cmd_pi, 7);

    // R11: repeated firmware-up with a link event between
    put_evt(12'h001, 12'h000);
    put_evt(12'h001, 12'h000);
    put_evt(12'h006, 12'h002);
    expect_up();
    expect_up();
    exp_eq.push_back({1'b0, 8'h5A, 12'h006, 12'h002});
    run_events();
    chk(exp_cq.size() == 0, "R11 two complete pairs in order", exp_cq.size(), 0);
    chk(exp_eq.size() == 0, "R11 later event still drained", exp_eq.size(), 0);
    chk(cmd_pi == 11, "R11 index after two pairs", cmd_pi, 11);

    // R4: bring-up pair stays adjacent under a continuous host stream
    log_mode = 1;
    wlog.delete();
    put_evt(12'h001, 12'h000);
    fork
      for (int i = 0; i < 6; i++) host_send(32'h3300_0000 | i, 0);
      begin
        repeat (2) @(negedge clk);
        run_events();
      end
    join
    repeat (8) @(negedge clk);
    log_mode = 0;
    exp_pi = (exp_pi + 8) % 64;
    chk(wlog.size() == 8, "R4 eight writes logged", wlog.size(), 8);
    k = -1;
    for (int i = 0; i < wlog.size(); i++) if (wlog[i] == UP0 && k < 0) k = i;
    chk(k >= 0 && k < 7 && wlog[k + 1] == UP1, "R4 bring-up pair adjacent",
        k, 0);
    n = 0;
    for (int i = 0; i < wlog.size(); i++)
      if (wlog[i] != UP0 && wlog[i] != UP1) begin
        chk(wlog[i] == (32'h3300_0000 | n), "R4 host order kept", wlog[i], 32'h3300_0000 | n);
        n++;
      end
    chk(cmd_pi == 6'(exp_pi), "R4 index after mixed stream", cmd_pi, exp_pi);

    // R5: event ring wrap
    for (int i = 0; i < 250; i++) put_evt(12'h0C0, 12'(i));
    run_events();
    chk(ev_ci == 8'(wp), "R5 consumer wraps modulo 256", ev_ci, wp);
    put_evt(12'h007, 12'h123);
    exp_eq.push_back({1'b1, 8'h5A, 12'h007, 12'h123});
    run_events();
    chk(exp_eq.size() == 0 && ev_ci == 8'(wp), "R5 event after wrap decoded",
        ev_ci, wp);
    chk(exp_cq.size() == 0, "R2 scoreboard drained", exp_cq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule